// File: doc/BRIEF.md
# Flit-to-packet reassembly queue

This block sits on the ejection side of one virtual channel of a router's local port. Flits arrive one per cycle at most, each tagged with a kind (head, body, tail, or a single flit that is both head and tail), a destination-core bit and a payload. The block writes each payload into a rebuild register, one slot per flit. When the closing flit of a packet arrives, the rebuilt packet is pushed into a packet FIFO, where it waits until the consuming tile component takes it.

Two controllers can share the same virtual channel. To support this, a filter parameter picks one of three variants. The generic variant queues every packet. The cache-side variant queues only packets whose header named the cache. The directory-side variant queues only packets whose header named the directory.

A back-pressure output tells the router to stop sending while a small reserve of FIFO slots is still free. This reserve absorbs single-flit packets that are already in flight in the router crossbar stage and in this block's own assembly stage.

Top module: `flit_reasm_queue`

## Requirements
- R1: After reset the packet-valid output and the back-pressure output are both low.
- R2: The payload of the k-th flit of a packet (k counted from 0) lands in bits [k*FLIT_W +: FLIT_W] of the rebuilt packet. For example, payloads 0x20, 0x40, 0x60, 0x10 rebuild as 0x10604020.
- R3: A flit of kind tail (2'd2) or single (2'd3) closes the packet. The next flit is written to slot 0. Slots that a shorter packet does not write keep their previous contents. A closed packet appears at the output two clock edges after the closing flit is sampled.
- R4: A flit of kind head (2'd0) or single (2'd3) captures the destination-core bit for its packet: 0 means the cache side and 1 means the directory side. Body flits (2'd1) leave it unchanged.
- R5: With FILTER=0 every closed packet is queued. With FILTER=1 only packets whose destination bit is 0 are queued. With FILTER=2 only packets whose destination bit is 1 are queued. A packet that is filtered out leaves the queue unchanged.
- R6: Each closed packet is queued exactly once.
- R7: The back-pressure output is high exactly when the FIFO holds DEPTH-RESERVE or more packets.
- R8: The packet-valid output is high whenever the FIFO is not empty, and the packet output then shows the oldest packet. A consumed pulse removes exactly one packet. A consumed pulse while the FIFO is empty has no effect.
- R9: A queue write and a consumed pulse in the same cycle leave the occupancy unchanged.
- R10: If single-flit packets arrive back to back, and the sender stops as soon as it sees back-pressure, then no packet is lost and all packets leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | A flit is present this cycle |
| flit_kind_i | input | 2 | 0 head, 1 body, 2 tail, 3 single |
| flit_dest_i | input | 1 | Destination core: 0 cache, 1 directory |
| flit_data_i | input | FLIT_W (8) | Flit payload |
| pkt_valid_o | output | 1 | Packet FIFO is not empty |
| pkt_data_o | output | FLIT_W*FLITS (32) | Oldest rebuilt packet |
| consumed_i | input | 1 | Consumer takes the oldest packet |
| credit_o | output | 1 | Back-pressure to the router |

## Verification
A closing flit sampled at one rising edge sets the completion flag at that edge. The packet enters the FIFO at the following edge, so it is visible at the output two edges after sampling. A consumed pulse shows its effect one edge later, and back-pressure follows the occupancy with no added delay. The bench drives inputs and compares outputs on falling edges. It keeps a behavioural model, with one rebuild array and one packet queue per filter variant, that applies exactly these delays at each rising edge. It compares valid, data and back-pressure of three instances against that model every cycle. Directed checks are placed only at falling edges that are already two edges past the closing flit.

// File: rtl/fr_pkg.sv
`timescale 1ns/1ps
package fr_pkg;
   typedef enum logic [1:0] {
      FK_HEAD   = 2'd0,
      FK_BODY   = 2'd1,
      FK_TAIL   = 2'd2,
      FK_SINGLE = 2'd3
   } flit_kind_e;

   localparam logic CORE_CACHE = 1'b0;
   localparam logic CORE_DIR   = 1'b1;

   localparam int FILT_GENERIC = 0;
   localparam int FILT_CACHE   = 1;
   localparam int FILT_DIR     = 2;
endpackage

// File: rtl/fr_assembler.sv
`timescale 1ns/1ps
module fr_assembler
   import fr_pkg::*;
#(
   parameter int FLIT_W = 8,
   parameter int FLITS  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [1:0]                in_kind,
   input  logic                      in_dest,
   input  logic [FLIT_W-1:0]         in_data,
   output logic                      done_o,
   output logic                      for_cache_o,
   output logic                      for_dir_o,
   output logic [FLIT_W*FLITS-1:0]   pkt_o
);
   localparam int CNT_W = $clog2(FLITS);
   typedef logic [CNT_W-1:0] cnt_t;

   cnt_t cnt_q;
   logic done_q, fc_q, fd_q;
   logic opens, closes;

   assign opens  = in_valid && (in_kind == FK_HEAD || in_kind == FK_SINGLE);
   assign closes = in_valid && (in_kind == FK_TAIL || in_kind == FK_SINGLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= closes;
         if (closes)        cnt_q <= '0;
         else if (in_valid) cnt_q <= cnt_q + cnt_t'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fc_q <= 1'b0;
         fd_q <= 1'b0;
      end else if (opens) begin
         fc_q <= (in_dest == CORE_CACHE);
         fd_q <= (in_dest == CORE_DIR);
      end
   end

   for (genvar i = 0; i < FLITS; i++) begin : g_slot
      logic [FLIT_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               slot_q <= '0;
         else if (in_valid && cnt_q == cnt_t'(i))  slot_q <= in_data;
      end
      assign pkt_o[i*FLIT_W +: FLIT_W] = slot_q;
   end

   assign done_o      = done_q;
   assign for_cache_o = fc_q;
   assign for_dir_o   = fd_q;

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      closes |=> (cnt_q == '0) && done_q); // R3
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !closes) |=> cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1))); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !closes) |=> !done_q); // R6
   AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!opens) |=> $stable(fc_q) && $stable(fd_q)); // R4
endmodule

// File: rtl/fr_enq_filter.sv
`timescale 1ns/1ps
module fr_enq_filter
   import fr_pkg::*;
#(
   parameter int FILTER = FILT_GENERIC
) (
   input  logic done_i,
   input  logic for_cache_i,
   input  logic for_dir_i,
   output logic enq_o
);
   if (FILTER == FILT_CACHE) begin : g_cache
      logic unused_dir;
      assign unused_dir = for_dir_i;
      assign enq_o      = done_i & for_cache_i;
   end else if (FILTER == FILT_DIR) begin : g_dir
      logic unused_cache;
      assign unused_cache = for_cache_i;
      assign enq_o        = done_i & for_dir_i;
   end else begin : g_generic
      logic unused_flags;
      assign unused_flags = for_cache_i ^ for_dir_i;
      assign enq_o        = done_i;
   end
endmodule

// File: rtl/fr_fifo.sv
`timescale 1ns/1ps
module fr_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [W-1:0]                wr_data,
   input  logic                        rd_en,
   output logic [W-1:0]                rd_data,
   output logic                        empty_o,
   output logic [$clog2(DEPTH+1)-1:0]  occ_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int OCC_W = $clog2(DEPTH+1);
   localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(DEPTH);
   typedef logic [PTR_W-1:0] ptr_t;

   logic [W-1:0]     mem_q [DEPTH];
   ptr_t             wp_q, rp_q;
   logic [OCC_W-1:0] occ_q;
   logic             full, empty, rd_ok, wr_ok;

   assign full  = (occ_q == FULL_LVL);
   assign empty = (occ_q == '0);
   assign rd_ok = rd_en && !empty;
   assign wr_ok = wr_en && (!full || rd_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         occ_q <= '0;
      end else begin
         if (wr_ok) wp_q <= wp_q + ptr_t'(1);
         if (rd_ok) rp_q <= rp_q + ptr_t'(1);
         if (wr_ok && !rd_ok)      occ_q <= occ_q + OCC_W'(1);
         else if (rd_ok && !wr_ok) occ_q <= occ_q - OCC_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem_q[wp_q] <= wr_data;
   end

   assign rd_data = mem_q[rp_q];
   assign empty_o = empty;
   assign occ_o   = occ_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |-> rd_en); // R10
   AST_OCC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && rd_ok) |=> occ_q == $past(occ_q)); // R9
   AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && !wr_ok) |=> occ_q == $past(occ_q) - OCC_W'(1)); // R8
endmodule

// File: rtl/flit_reasm_queue.sv
`timescale 1ns/1ps
module flit_reasm_queue
   import fr_pkg::*;
#(
   parameter int FLIT_W  = 8,
   parameter int FLITS   = 4,
   parameter int DEPTH   = 8,
   parameter int RESERVE = 2,
   parameter int FILTER  = FILT_GENERIC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flit_valid_i,
   input  logic [1:0]               flit_kind_i,
   input  logic                     flit_dest_i,
   input  logic [FLIT_W-1:0]        flit_data_i,
   output logic                     pkt_valid_o,
   output logic [FLIT_W*FLITS-1:0]  pkt_data_o,
   input  logic                     consumed_i,
   output logic                     credit_o
);
   localparam int PKT_W = FLIT_W * FLITS;
   localparam int OCC_W = $clog2(DEPTH + 1);
   localparam logic [OCC_W-1:0] STOP_LVL = OCC_W'(DEPTH - RESERVE);

   if (FLITS < 2 || (FLITS & (FLITS - 1)) != 0) begin : g_bad_flits
      $error("FLITS must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (RESERVE < 1 || RESERVE >= DEPTH) begin : g_bad_reserve
      $error("RESERVE must lie between 1 and DEPTH-1");
   end
   if (FILTER < FILT_GENERIC || FILTER > FILT_DIR) begin : g_bad_filter
      $error("FILTER must be 0, 1 or 2");
   end

   logic             done, for_cache, for_dir, enq, empty;
   logic [PKT_W-1:0] rebuilt;
   logic [OCC_W-1:0] occ;

   fr_assembler #(.FLIT_W(FLIT_W), .FLITS(FLITS)) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (flit_valid_i),
      .in_kind     (flit_kind_i),
      .in_dest     (flit_dest_i),
      .in_data     (flit_data_i),
      .done_o      (done),
      .for_cache_o (for_cache),
      .for_dir_o   (for_dir),
      .pkt_o       (rebuilt)
   );

   fr_enq_filter #(.FILTER(FILTER)) u_filt (
      .done_i      (done),
      .for_cache_i (for_cache),
      .for_dir_i   (for_dir),
      .enq_o       (enq)
   );

   fr_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (enq),
      .wr_data (rebuilt),
      .rd_en   (consumed_i),
      .rd_data (pkt_data_o),
      .empty_o (empty),
      .occ_o   (occ)
   );

   assign pkt_valid_o = !empty;
   assign credit_o    = (occ >= STOP_LVL);

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_o && !consumed_i) |=> pkt_valid_o && $stable(pkt_data_o)); // R8
   AST_EMPTY_STAY: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_valid_o && !enq) |=> !pkt_valid_o); // R8
   AST_FILTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!enq && !consumed_i) |=> $stable(occ)); // R5
   AST_CREDIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(credit_o) |-> $past(enq)); // R7
endmodule

// File: tb/sim_flit_reasm_queue.sv
`timescale 1ns/1ps
module sim_ref #(
   parameter int MODE   = 0,
   parameter int FLIT_W = 8,
   parameter int FLITS  = 4,
   parameter int DEPTH  = 8,
   parameter int RSV    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fv,
   input  logic [1:0]              kind,
   input  logic                    dest,
   input  logic [FLIT_W-1:0]       data,
   input  logic                    consumed,
   output logic                    exp_valid,
   output logic [FLIT_W*FLITS-1:0] exp_data,
   output logic                    exp_credit
);
   logic [FLIT_W-1:0]       slot [FLITS];
   logic [FLIT_W*FLITS-1:0] q [$];
   logic [FLIT_W*FLITS-1:0] pend_pkt;
   int cnt;
   bit pend, to_cache, to_dir;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt = 0; pend = 0; to_cache = 0; to_dir = 0;
         for (int j = 0; j < FLITS; j++) slot[j] = '0;
         q.delete();
      end else begin
         if (consumed && q.size() > 0) void'(q.pop_front());
         if (pend) q.push_back(pend_pkt);
         pend = 0;
         if (fv) begin
            slot[cnt] = data;
            if (kind == 2'd0 || kind == 2'd3) begin
               to_cache = (dest == 1'b0);
               to_dir   = (dest == 1'b1);
            end
            if (kind == 2'd2 || kind == 2'd3) begin
               cnt  = 0;
               pend = (MODE == 0) ? 1'b1 : (MODE == 1) ? to_cache : to_dir;
               for (int j = 0; j < FLITS; j++) pend_pkt[j*FLIT_W +: FLIT_W] = slot[j];
            end else begin
               cnt = (cnt + 1) % FLITS;
            end
         end
      end
      exp_valid  = (q.size() != 0);
      exp_data   = (q.size() != 0) ? q[0] : '0;
      exp_credit = (q.size() >= DEPTH - RSV);
   end
endmodule

module sim_flit_reasm_queue;
   localparam int FLIT_W = 8;
   localparam int FLITS  = 4;
   localparam int DEPTH  = 8;
   localparam int PKT_W  = FLIT_W * FLITS;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n = 1'b0, fv = 1'b0, dest = 1'b0, consumed = 1'b0;
   logic [1:0]       kind = 2'd0;
   logic [FLIT_W-1:0] data = '0;
   logic [2:0]       pv, cr, ev, ec;
   logic [PKT_W-1:0] pd [3];
   logic [PKT_W-1:0] ed [3];
   int errs = 0, checks = 0;

   flit_reasm_queue #(.FILTER(0)) u0 (.clk(clk), .rst_n(rst_n), .flit_valid_i(fv),
      .flit_kind_i(kind), .flit_dest_i(dest), .flit_data_i(data), .pkt_valid_o(pv[0]),
      .pkt_data_o(pd[0]), .consumed_i(consumed), .credit_o(cr[0]));
   flit_reasm_queue #(.FILTER(1)) u1 (.clk(clk), .rst_n(rst_n), .flit_valid_i(fv),
      .flit_kind_i(kind), .flit_dest_i(dest), .flit_data_i(data), .pkt_valid_o(pv[1]),
      .pkt_data_o(pd[1]), .consumed_i(consumed), .credit_o(cr[1]));
   flit_reasm_queue #(.FILTER(2)) u2 (.clk(clk), .rst_n(rst_n), .flit_valid_i(fv),
      .flit_kind_i(kind), .flit_dest_i(dest), .flit_data_i(data), .pkt_valid_o(pv[2]),
      .pkt_data_o(pd[2]), .consumed_i(consumed), .credit_o(cr[2]));

   sim_ref #(.MODE(0)) m0 (.clk(clk), .rst_n(rst_n), .fv(fv), .kind(kind), .dest(dest),
      .data(data), .consumed(consumed), .exp_valid(ev[0]), .exp_data(ed[0]), .exp_credit(ec[0]));
   sim_ref #(.MODE(1)) m1 (.clk(clk), .rst_n(rst_n), .fv(fv), .kind(kind), .dest(dest),
      .data(data), .consumed(consumed), .exp_valid(ev[1]), .exp_data(ed[1]), .exp_credit(ec[1]));
   sim_ref #(.MODE(2)) m2 (.clk(clk), .rst_n(rst_n), .fv(fv), .kind(kind), .dest(dest),
      .data(data), .consumed(consumed), .exp_valid(ev[2]), .exp_data(ed[2]), .exp_credit(ec[2]));

   task automatic chk(input bit ok, input string req, input logic [PKT_W-1:0] act,
                      input logic [PKT_W-1:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // cycle-by-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 3; i++) begin
            chk(pv[i] == ev[i], "R8 valid", {31'd0, pv[i]}, {31'd0, ev[i]});
            if (ev[i]) chk(pd[i] == ed[i], "R2 data", pd[i], ed[i]);
            chk(cr[i] == ec[i], "R7 credit", {31'd0, cr[i]}, {31'd0, ec[i]});
         end
      end
   end

   task automatic send(input logic [1:0] k, input logic d, input logic [7:0] x);
      @(negedge clk);
      fv = 1'b1; kind = k; dest = d; data = x;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fv = 1'b0;
      end
   endtask

   task automatic pulse_consume();
      @(negedge clk);
      fv = 1'b0; consumed = 1'b1;
      @(negedge clk);
      consumed = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      errs++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int sent, got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pv == 3'b000, "R1 valid after reset", {29'd0, pv}, 0);
      chk(cr == 3'b000, "R1 credit after reset", {29'd0, cr}, 0);

      // R2: four-flit packet to the cache side
      send(2'd0, 1'b0, 8'h20);
      send(2'd1, 1'b0, 8'h40);
      send(2'd1, 1'b0, 8'h60);
      send(2'd2, 1'b0, 8'h10);
      idle(2);
      chk(pv[0] && pd[0] == 32'h10604020, "R2 generic rebuild", pd[0], 32'h10604020);
      chk(pv[1] && pd[1] == 32'h10604020, "R5 cache side queued", pd[1], 32'h10604020);
      chk(!pv[2], "R5 directory side filtered", {31'd0, pv[2]}, 0);

      // R3/R4: short packet to the directory side, upper slots keep old data
      send(2'd0, 1'b1, 8'hA1);
      send(2'd2, 1'b1, 8'hB2);
      idle(2);
      chk(pv[2] && pd[2] == 32'h1060B2A1, "R3 R4 directory rebuild", pd[2], 32'h1060B2A1);

      pulse_consume();
      chk(!pv[1], "R6 single enqueue per packet", {31'd0, pv[1]}, 0);
      chk(pv[0] && pd[0][15:0] == 16'hB2A1, "R8 one packet removed", pd[0], 32'h1060B2A1);
      chk(!pv[2], "R8 directory queue drained", {31'd0, pv[2]}, 0);
      pulse_consume();
      pulse_consume();
      pulse_consume();
      chk(pv == 3'b000, "R8 consume on empty ignored", {29'd0, pv}, 0);

      // R9: stream single flits while consuming every cycle
      send(2'd3, 1'b0, 8'h5A);
      idle(2);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         fv = 1'b1; kind = 2'd3; dest = 1'b0; data = 8'h30 + 8'(i); consumed = 1'b1;
      end
      chk(pv[0] && !cr[0], "R9 occupancy steady", {30'd0, pv[0], cr[0]}, 2);
      @(negedge clk);
      fv = 1'b0; consumed = 1'b0;
      idle(2);
      while (pv[0]) pulse_consume();

      // R10: back-to-back single flits until back-pressure
      sent = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (cr[0]) begin
            fv = 1'b0;
            break;
         end
         fv = 1'b1; kind = 2'd3; dest = 1'b0; data = 8'h80 + 8'(sent);
         sent++;
      end
      chk(cr[0] == 1'b1, "R7 back-pressure reached", {31'd0, cr[0]}, 1);
      idle(3);
      got = 0;
      while (pv[0] && got < 40) begin
         chk(pd[0][7:0] == 8'h80 + 8'(got), "R10 order", pd[0], {24'd0, 8'h80 + 8'(got)});
         consumed = 1'b1;
         @(negedge clk);
         consumed = 1'b0;
         got++;
      end
      chk(got == sent, "R10 no packet lost", got, sent);
      idle(2);
      finish_run();
   end
endmodule